// File: doc/BRIEF.md
# Kleene-Star Reach Engine for Bit-Parallel Streams

This block takes two bit streams that run parallel to a text, one block per clock. The first stream holds match markers, and the second holds the members of a character class. It returns a stream that marks every text position a marker can reach by stepping across zero or more consecutive class positions. Bit 0 of each block is the earliest character, and a set bit means "the next character to be matched is here". The whole block is resolved in one pass: the markers that sit on class bits are added to the class stream, the class stream is XORed back out, and the original markers are ORed in. A single carry chain therefore marks every position inside and just past each run, not only the end of the longest run. This is what an ambiguous pattern such as a digit-star between two literals needs.

A run can cross a block boundary. For that case, the carry out of the top bit is saved and injected at bit 0 of the next valid block. A stream-start strobe discards that saved carry. When the strobe comes with a block, that block is computed with a zero carry-in. When it comes on its own, it clears the saved carry. Results appear one cycle after the block is accepted.

Top module: `msx_engine`

## Requirements
- R1: After reset, `res_vld` and `reach` are 0 and the saved carry is 0, so a first block sent without `strm_start` is computed with carry-in 0.
- R2: One cycle after `blk_vld` is high, `res_vld` is high and `reach` equals ((M & C) + C + cin) ^ C) | M. Here M is `mark`, C is `cls`, bit 0 is the lowest addend bit, and cin is the saved carry. `res_vld` is low one cycle after `blk_vld` is low.
- R3: Every marker bit of an accepted block is set in its result, including markers that are not on a class bit.
- R4: Every position from a marker through the end of its class run is marked, plus the position just past the run. Two markers in one run both contribute, so all intermediate positions are marked.
- R5: The carry out of bit BLK_W-1 of an accepted block is added at bit 0 of the next accepted block. A run that ends exactly at the block's top bit therefore marks bit 0 of the following block.
- R6: When `strm_start` is high together with `blk_vld`, that block uses carry-in 0 whatever carry was saved. When `strm_start` is high without `blk_vld`, the saved carry is cleared.
- R7: Cycles without `blk_vld` leave `reach` and the saved carry unchanged.
- R8: A result bit is set only where the block has a marker or a class bit, or directly after a class bit. Bit 0 is excepted, because the carry-in can set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strm_start | input | 1 | Start of a new stream; discards the saved carry |
| blk_vld | input | 1 | A block is presented on `mark` and `cls` |
| mark | input | BLK_W | Marker stream block, bit 0 earliest |
| cls | input | BLK_W | Character-class stream block, bit 0 earliest |
| res_vld | output | 1 | `reach` holds the result of the block accepted last cycle |
| reach | output | BLK_W | Reachable-position stream block |

## Verification
Two functions can land in one cycle: the stream-start clear and the use of a saved carry. The bench leaves a carry of 1 pending by ending a run at the top bit. It then sends the next block with `strm_start` raised and a class run at bit 0, and checks that the run is not marked. A carry sent without the strobe would have marked it. The same pending carry is also checked after idle gaps and after a strobe sent alone. Chained random blocks are compared against a bit-serial reference that walks one position at a time.

// File: rtl/msx_pkg.sv
package msx_pkg;
    localparam int unsigned MSX_BLK_W  = 64;
    localparam int unsigned MSX_LIMB_W = 16;

    function automatic int unsigned limb_count(int unsigned w, int unsigned l);
        return (w + l - 1) / l;
    endfunction
endpackage

// File: rtl/msx_blk_add.sv
module msx_blk_add #(
    parameter int unsigned W      = msx_pkg::MSX_BLK_W,
    parameter int unsigned LIMB_W = msx_pkg::MSX_LIMB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int unsigned NLIMB = msx_pkg::limb_count(W, LIMB_W);

    logic [NLIMB:0] chain;
    assign chain[0] = cin;

    for (genvar g = 0; g < NLIMB; g++) begin : g_limb
        localparam int unsigned LO = g * LIMB_W;
        localparam int unsigned HI = ((g + 1) * LIMB_W > W) ? W - 1 : (g + 1) * LIMB_W - 1;
        localparam int unsigned SW = HI - LO + 1;
        logic [SW:0] part;
        always_comb begin
            part = {1'b0, a[HI:LO]} + {1'b0, b[HI:LO]} + {{SW{1'b0}}, chain[g]};
        end
        assign sum[HI:LO]  = part[SW-1:0];
        assign chain[g+1]  = part[SW];
    end

    assign cout = chain[NLIMB];
endmodule

// File: rtl/msx_star_core.sv
module msx_star_core #(
    parameter int unsigned W      = msx_pkg::MSX_BLK_W,
    parameter int unsigned LIMB_W = msx_pkg::MSX_LIMB_W
) (
    input  logic [W-1:0] mk,
    input  logic [W-1:0] cc,
    input  logic         cin,
    output logic [W-1:0] reach_c,
    output logic         cout
);
    logic [W-1:0] seed;
    logic [W-1:0] total;

    assign seed = mk & cc;

    msx_blk_add #(.W(W), .LIMB_W(LIMB_W)) u_add (
        .a    (seed),
        .b    (cc),
        .cin  (cin),
        .sum  (total),
        .cout (cout)
    );

    assign reach_c = (total ^ cc) | mk;
endmodule

// File: rtl/msx_engine.sv
module msx_engine #(
    parameter int unsigned BLK_W  = msx_pkg::MSX_BLK_W,
    parameter int unsigned LIMB_W = msx_pkg::MSX_LIMB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strm_start,
    input  logic             blk_vld,
    input  logic [BLK_W-1:0] mark,
    input  logic [BLK_W-1:0] cls,
    output logic             res_vld,
    output logic [BLK_W-1:0] reach
);
    typedef struct packed {
        logic             carry;
        logic             vld;
        logic [BLK_W-1:0] res;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic             cin_use;
    logic [BLK_W-1:0] core_res;
    logic             core_cout;

    assign cin_use = strm_start ? 1'b0 : st_q.carry;

    msx_star_core #(.W(BLK_W), .LIMB_W(LIMB_W)) u_core (
        .mk      (mark),
        .cc      (cls),
        .cin     (cin_use),
        .reach_c (core_res),
        .cout    (core_cout)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = blk_vld;
        if (blk_vld) begin
            st_d.res   = core_res;
            st_d.carry = core_cout;
        end else if (strm_start) begin
            st_d.carry = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld = st_q.vld;
    assign reach   = st_q.res;
endmodule

// File: rtl/msx_engine_chk.sv
module msx_engine_chk #(
    parameter int unsigned BLK_W = msx_pkg::MSX_BLK_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strm_start,
    input logic             blk_vld,
    input logic [BLK_W-1:0] mark,
    input logic [BLK_W-1:0] cls,
    input logic             res_vld,
    input logic [BLK_W-1:0] reach
);
    // R2
    result_follows_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_vld |=> res_vld);

    // R2
    no_result_without_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_vld |=> !res_vld);

    // R3
    markers_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_vld |=> ((reach & $past(mark)) == $past(mark)));

    // R6
    start_drops_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_vld && strm_start && cls == '0) |=> (reach == $past(mark)));

    // R7
    idle_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_vld |=> $stable(reach));

    // R8
    result_support_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_vld |=> ((reach & ~$past(mark) & ~$past(cls)
                      & ~{$past(cls[BLK_W-2:0]), 1'b1}) == '0));
endmodule

bind msx_engine msx_engine_chk #(.BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strm_start (strm_start),
    .blk_vld    (blk_vld),
    .mark       (mark),
    .cls        (cls),
    .res_vld    (res_vld),
    .reach      (reach)
);

// File: tb/sim_msx_engine.sv
module sim_msx_engine;
    localparam int unsigned W      = 16;
    localparam int unsigned LW     = 4;
    localparam time         CLK_PER = 10ns;
    localparam int unsigned NVEC   = 10;

    // {start, mark, cls, expected reach}
    localparam logic [3*W:0] VEC [NVEC] = '{
        {1'b1, 16'h0001, 16'h000E, 16'h0001},  // R3 marker not on class
        {1'b0, 16'h0002, 16'h000E, 16'h001E},  // R4 run plus next
        {1'b0, 16'h0104, 16'h0F0C, 16'h1F1C},  // R4 two markers, two runs
        {1'b0, 16'h4000, 16'hC000, 16'hC000},  // R5 run to top bit
        {1'b0, 16'h0000, 16'h0003, 16'h0007},  // R5 carry continues run
        {1'b0, 16'h8000, 16'h8000, 16'h8000},  // R5 carry set again
        {1'b1, 16'h0000, 16'h0003, 16'h0000},  // R6 start beats pending carry
        {1'b0, 16'h8000, 16'h8000, 16'h8000},  // R5 carry set
        {1'b0, 16'h0000, 16'h0000, 16'h0001},  // R5 carry lands on bit 0
        {1'b0, 16'h0010, 16'h0000, 16'h0010}   // R3 lone marker
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strm_start = 1'b0;
    logic         blk_vld = 1'b0;
    logic [W-1:0] mark = '0;
    logic [W-1:0] cls = '0;
    logic         res_vld;
    logic [W-1:0] reach;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    msx_engine #(.BLK_W(W), .LIMB_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .strm_start(strm_start), .blk_vld(blk_vld),
        .mark(mark), .cls(cls), .res_vld(res_vld), .reach(reach)
    );

    function automatic logic [W:0] serial_ref(logic [W-1:0] m, logic [W-1:0] c, logic ci);
        logic [W-1:0] r;
        logic carry;
        carry = ci;
        for (int i = 0; i < W; i++) begin
            r[i]  = m[i] | carry;
            carry = r[i] & c[i];
        end
        return {carry, r};
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(logic st, logic [W-1:0] m, logic [W-1:0] c);
        @(negedge clk);
        strm_start = st; blk_vld = 1'b1; mark = m; cls = c;
        @(negedge clk);
        strm_start = 1'b0; blk_vld = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [W:0] rv;
        logic       car;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 vld", {15'd0, res_vld}, 16'd0);
        chk("R1 reach", reach, 16'd0);
        rst_n = 1'b1;
        send(1'b0, 16'h0000, 16'h0000);
        chk("R1 carry clear", reach, 16'h0000);

        for (int k = 0; k < NVEC; k++) begin
            send(VEC[k][3*W], VEC[k][3*W-1:2*W], VEC[k][2*W-1:W]);
            chk("R2 vld", {15'd0, res_vld}, 16'd1);
            chk($sformatf("R2 vec%0d", k), reach, VEC[k][W-1:0]);
        end

        // R7 idle gap keeps result and carry
        send(1'b0, 16'h8000, 16'h8000);
        repeat (3) @(negedge clk);
        chk("R7 vld low", {15'd0, res_vld}, 16'd0);
        chk("R7 held", reach, 16'h8000);
        send(1'b0, 16'h0000, 16'h0000);
        chk("R7 carry kept", reach, 16'h0001);

        // R6 standalone start clears carry
        send(1'b0, 16'h8000, 16'h8000);
        @(negedge clk);
        strm_start = 1'b1;
        @(negedge clk);
        strm_start = 1'b0;
        chk("R6 start alone held", reach, 16'h8000);
        send(1'b0, 16'h0000, 16'h0001);
        chk("R6 start alone", reach, 16'h0000);

        // R1 reset clears pending carry
        send(1'b0, 16'h8000, 16'h8000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        send(1'b0, 16'h0000, 16'h0000);
        chk("R1 reset carry", reach, 16'h0000);

        // R2 R5 chained random blocks vs serial reference
        car = 1'b0;
        for (int k = 0; k < 60; k++) begin
            logic [W-1:0] m, c;
            logic st;
            m  = 16'($urandom) & 16'($urandom);
            c  = 16'($urandom) | 16'($urandom);
            st = (k % 20 == 0);
            rv = serial_ref(m, c, st ? 1'b0 : car);
            car = rv[W];
            send(st, m, c);
            chk($sformatf("R5 chain%0d", k), reach, rv[W-1:0]);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule